// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Read Port

This block is the digital half of a 16-bit sampling converter's serial read port. A rising edge on the convert input starts a conversion. A busy flag then stays high for a fixed, parameterised number of clock cycles. When the conversion ends, the signed 16-bit result is taken from a parallel input, which stands in for the analog core, and loaded into a shift register. The host clocks the result out most significant bit first with a serial clock.

One input pin serves two purposes, and a mode pin picks which. In normal mode the pin is an active-low output enable for the serial data line. In chain mode the serial data line is always driven, and the pin becomes a serial data input that feeds the least significant end of the shift register. Several converters can then be wired output-to-input, and the host reads all of their results through the last converter in the line.

All inputs are sampled in the `clk_i` domain. The convert input and the serial clock act on their rising edges as seen in that domain.

Top module: `conv_serial_port`

## Requirements
- R1: While `rst_ni` is low and after it is released, `busy_o` is 0 and the shift register holds all zeros, so `sdo_o` reads 0 through any number of serial clocks in normal mode.
- R2: A 0-to-1 transition on `conv_i` with `busy_o` low sets `busy_o` at the next clock edge. `busy_o` then stays high for exactly `CONV_CYCLES` clock cycles.
- R3: A rising edge on `conv_i` while `busy_o` is high is ignored: the busy period neither restarts nor gets longer.
- R4: `result_i` is captured at the clock edge on which `busy_o` falls. Values applied to it earlier in the busy period, or after it, are not used. Bit 15 of the captured word appears on `sdo_o` before any serial clock.
- R5: Each rising edge of `sck_i` shifts the register one place toward the MSB, so `sdo_o` presents the word MSB first. In normal mode a 0 enters the LSB.
- R6: In normal mode (`chain_mode_i` = 0), `sdo_oe_o` is the inverse of `en_sdi_i`: the output is driven when the pin is 0 and released when it is 1.
- R7: In chain mode (`chain_mode_i` = 1), `sdo_oe_o` is 1, and on each rising edge of `sck_i` the value of `en_sdi_i` enters the LSB. After 16 edges the register holds the 16 bits that were shifted in, first-in bit at the MSB.
- R8: When two ports are chained, the downstream one in chain mode with its `en_sdi_i` fed from the upstream `sdo_o`, 32 serial clocks after a shared conversion return the downstream result and then the upstream result, each MSB first in two's complement.
- R9: An `sck_i` level held high across several clock cycles counts as one edge and shifts once.
- R10: A `conv_i` level held high past the end of a conversion starts no further conversion until it goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert request, acts on its rising edge |
| chain_mode_i | input | 1 | 0 = normal mode, 1 = chain mode |
| en_sdi_i | input | 1 | Active-low output enable (normal mode) or serial data in (chain mode) |
| sck_i | input | 1 | Serial clock, shifts on its rising edge |
| result_i | input | 16 | Two's-complement result from the conversion core |
| busy_o | output | 1 | High while a conversion is running |
| sdo_o | output | 1 | Serial data out, MSB first |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |

## Verification
The hardest case to reach is a word crossing the chain link with no bit lost or doubled. The downstream register samples the upstream `sdo_o` at the same clock edge that also shifts the upstream register, so an off-by-one in either direction only shows up when two instances share the serial clock. The bench wires two ports together and loads distinct negative and positive values into them with one shared convert pulse. It then collects 32 bits, sampling each before its serial clock edge. Separate tests pulse the convert input in the middle of a busy period, hold the convert input and the serial clock high for many cycles, and change `result_i` both during and after the conversion, so that the capture edge and the edge detection are both pinned down.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;

  typedef enum logic {
    PORT_NORMAL = 1'b0,
    PORT_CHAIN  = 1'b1
  } port_mode_e;

  // bit entering the LSB on a shift
  function automatic logic shift_in_bit(port_mode_e mode, logic pin);
    return (mode == PORT_CHAIN) ? pin : 1'b0;
  endfunction

  function automatic logic out_enable(port_mode_e mode, logic pin);
    return (mode == PORT_CHAIN) ? 1'b1 : ~pin;
  endfunction

endpackage

// File: rtl/cp_edge_det.sv
module cp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

  // a held level yields one event (R9 for sck, R10 for conv)
  assert_single_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/cp_conv_timer.sv
module cp_conv_timer #(
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = start_i & ~busy_q;
  assign done_o = busy_q & (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LAST;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_start_sets_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && cnt_q == CNT_LAST));

  assert_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  assert_done_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_q || $past(start_i)) == !busy_q);

endmodule

// File: rtl/cp_shift_reg.sv
module cp_shift_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              lsb_i,
  output logic              msb_o
);

  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[WORD_W-2:0], lsb_i};
  end

  assign msb_o = sreg_q[WORD_W-1];

  assert_load_captures_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sreg_q == $past(data_i));

  assert_shift_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (sreg_q[WORD_W-1:1] == $past(sreg_q[WORD_W-2:0])
                              && sreg_q[0] == $past(lsb_i)));

  assert_idle_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(sreg_q));

endmodule

// File: rtl/cp_out_stage.sv
module cp_out_stage
  import conv_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  port_mode_e mode_i,
  input  logic       pin_i,
  input  logic       msb_i,
  output logic       sdo_o,
  output logic       sdo_oe_o
);

  assign sdo_o    = msb_i;
  assign sdo_oe_o = out_enable(mode_i, pin_i);

  assert_chain_drives_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PORT_CHAIN) |-> sdo_oe_o);

  assert_enable_low_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PORT_NORMAL) |-> (sdo_oe_o != pin_i));

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_port_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CONV_CYCLES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              chain_mode_i,
  input  logic              en_sdi_i,
  input  logic              sck_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              busy_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);

  port_mode_e mode;
  logic       conv_rise;
  logic       sck_rise;
  logic       conv_done;
  logic       msb;

  assign mode = port_mode_e'(chain_mode_i);

  cp_edge_det u_conv_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (conv_i),
    .rise_o (conv_rise)
  );

  cp_edge_det u_sck_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sck_i),
    .rise_o (sck_rise)
  );

  cp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (conv_rise),
    .busy_o  (busy_o),
    .done_o  (conv_done)
  );

  cp_shift_reg #(.WORD_W(WORD_W)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (conv_done),
    .data_i  (result_i),
    .shift_i (sck_rise),
    .lsb_i   (shift_in_bit(mode, en_sdi_i)),
    .msb_o   (msb)
  );

  cp_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .pin_i    (en_sdi_i),
    .msb_i    (msb),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  assert_busy_falls_on_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(conv_rise)) |-> sdo_o == $past(result_i[WORD_W-1]));

endmodule

// File: tb/conv_serial_port_tb_top.sv
module conv_serial_port_tb_top;

  localparam int unsigned W    = 16;
  localparam int unsigned CONV = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         conv = 1'b0;
  logic         sck = 1'b0;
  logic         chain_a = 1'b0;
  logic         use_up = 1'b0;
  logic         sdi_drv = 1'b0;
  logic [W-1:0] res_a = '0;
  logic [W-1:0] res_b = '0;
  logic         busy_a, sdo_a, oe_a;
  logic         busy_b, sdo_b, oe_b;
  logic         pin_a;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  assign pin_a = use_up ? sdo_b : sdi_drv;

  conv_serial_port #(.WORD_W(W), .CONV_CYCLES(CONV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .chain_mode_i(chain_a),
    .en_sdi_i(pin_a), .sck_i(sck), .result_i(res_a),
    .busy_o(busy_a), .sdo_o(sdo_a), .sdo_oe_o(oe_a)
  );

  // upstream device, normal mode, always enabled
  conv_serial_port #(.WORD_W(W), .CONV_CYCLES(CONV)) up_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .chain_mode_i(1'b0),
    .en_sdi_i(1'b0), .sck_i(sck), .result_i(res_b),
    .busy_o(busy_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sck_pulse();
    @(negedge clk) sck = 1'b1;
    @(negedge clk) sck = 1'b0;
  endtask

  task automatic read_bits(input int n, output logic [31:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[30:0], sdo_a};
      sck_pulse();
    end
  endtask

  task automatic do_conv();
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
    while (busy_a) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] w;
    @(negedge clk);
    chk("R1 busy in reset", busy_a, 0);
    chk("R1 sdo in reset", sdo_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy_a, 0);
    read_bits(16, w);
    chk("R1 register empty", w, 0);
  endtask

  task automatic t_conv_len();
    int len;
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
    chk("R2 busy rises", busy_a, 1);
    len = 1;
    while (busy_a) begin
      @(negedge clk);
      if (busy_a) len++;
    end
    chk("R2 busy length", len, CONV);
  endtask

  task automatic t_ignore_busy();
    int len;
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
    len = 1;
    while (busy_a) begin
      if (len == 6) conv = 1'b1;
      if (len == 7) conv = 1'b0;
      @(negedge clk);
      if (busy_a) len++;
    end
    chk("R3 edge during busy ignored", len, CONV);
    repeat (3) @(negedge clk);
    chk("R3 no restart", busy_a, 0);
  endtask

  task automatic t_conv_hold();
    int len = 0;
    @(negedge clk) conv = 1'b1;
    for (int i = 0; i < 3 * CONV; i++) begin
      @(negedge clk);
      if (busy_a) len++;
    end
    chk("R10 held conv gives one conversion", len, CONV);
    conv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_capture();
    logic [31:0] w;
    chain_a = 1'b0; use_up = 1'b0; sdi_drv = 1'b0;
    res_a = 16'h1111;
    @(negedge clk) conv = 1'b1;
    @(negedge clk) conv = 1'b0;
    repeat (4) @(negedge clk);
    res_a = 16'hCFC7; // -12345
    while (busy_a) @(negedge clk);
    res_a = 16'h0F0F;
    chk("R4 msb before sck", sdo_a, 1);
    read_bits(16, w);
    chk("R4 captured at busy end", w, 32'h0000CFC7);
  endtask

  task automatic t_normal_read();
    logic [31:0] w;
    res_a = 16'h7FFF;
    do_conv();
    read_bits(18, w);
    chk("R5 MSB first with zero fill", w, {14'd0, 16'h7FFF, 2'b00});
  endtask

  task automatic t_oe();
    chain_a = 1'b0; use_up = 1'b0;
    @(negedge clk) sdi_drv = 1'b1;
    #1 chk("R6 pin high releases", oe_a, 0);
    @(negedge clk) sdi_drv = 1'b0;
    #1 chk("R6 pin low drives", oe_a, 1);
    chain_a = 1'b1; sdi_drv = 1'b1;
    #1 chk("R7 chain drives", oe_a, 1);
    sdi_drv = 1'b0;
    #1 chk("R7 chain drives pin low", oe_a, 1);
    chain_a = 1'b0;
  endtask

  task automatic t_chain_in();
    logic [31:0] w;
    logic [15:0] pat = 16'hB3E1;
    chain_a = 1'b1; use_up = 1'b0;
    res_a = 16'h8000;
    do_conv();
    w = '0;
    for (int i = 0; i < 16; i++) begin
      sdi_drv = pat[15-i];
      w = {w[30:0], sdo_a};
      sck_pulse();
    end
    sdi_drv = 1'b0;
    chk("R7 own word out", w, 32'h00008000);
    read_bits(16, w);
    chk("R7 serial input captured", w, {16'd0, pat});
    chain_a = 1'b0;
  endtask

  task automatic t_sck_hold();
    res_a = 16'hA5C3;
    do_conv();
    @(negedge clk) sck = 1'b1;
    repeat (5) @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
    chk("R9 held sck shifts once", sdo_a, 0);
    sck_pulse();
    chk("R9 next shift", sdo_a, 1);
  endtask

  task automatic t_daisy();
    logic [31:0] w;
    chain_a = 1'b1; use_up = 1'b1;
    res_a = 16'hFFF9; // -7
    res_b = 16'h1234;
    do_conv();
    chk("R8 upstream done", busy_b, 0);
    read_bits(32, w);
    chk("R8 chained read", w, {16'hFFF9, 16'h1234});
    res_a = 16'h0005;
    res_b = 16'h8001; // -32767
    do_conv();
    read_bits(32, w);
    chk("R8 chained read second", w, {16'h0005, 16'h8001});
    chain_a = 1'b0; use_up = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_conv_len();
    t_ignore_busy();
    t_conv_hold();
    t_capture();
    t_normal_read();
    t_oe();
    t_chain_in();
    t_sck_hold();
    t_daisy();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule